// File: doc/BRIEF.md
# Six-Source Prioritized Interrupt Controller

This block gathers six interrupt sources and turns them into one request to a small processor core. Two are external pins, a high-rank one and a low-rank one. Four are internal events from on-chip counters: a fast timer overflow, a timer A overflow, a timer B overflow and a periodic time base.

Each source owns a pending latch. The latch is set by a rising edge on its source and cleared by reset, by a software clear strobe, or by the processor's acknowledge. Pending latches are gated by a global enable and by a 4-bit mask word. The highest-ranked eligible source is then captured, and the block raises `irq_o` with a fixed even entry address on `vec_o`.

That address and the request stay frozen until the core acknowledges. On acknowledge the block clears the granted latch and drops the global enable, so the service routine runs without being nested until software enables it again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is active and after it is released, `irq_o` is 0, `vec_o` is 0, every pending latch is clear and the global enable is off.
- R2: Rank 0 is the highest and rank 5 the lowest. The ranks are: ext high (`ext_req_i[0]`), fast timer (`tmr_evt_i[0]`), timer A (`tmr_evt_i[1]`), timer B (`tmr_evt_i[2]`), time base (`tmr_evt_i[3]`), ext low (`ext_req_i[1]`). The entry address is 0x002 + 2×rank, which gives 0x002 for rank 0 up to 0x00C for rank 5. Among the eligible pending sources, the lowest rank is granted.
- R3: A pending source is eligible only while the global enable is on. In addition, the fast timer needs `mask_i[3]`, timer A needs `mask_i[2]`, timer B needs `mask_i[1]` and ext low needs `mask_i[0]`. Ext high and the time base need only the global enable.
- R4: A latch is set by a 0→1 transition of its source, and a steady high level sets it only once. An internal event with all gates open raises `irq_o` two clock edges after the edge where it is sampled high. An external input passes through a two-flop synchronizer and raises `irq_o` four edges after it is first sampled high.
- R5: A pending source that is masked stays latched. It is granted once its mask bit is set, provided no lower-rank eligible source is pending.
- R6: `clr_i[k]` clears the latch of rank k. If a rising edge of that source arrives in the same cycle, the latch ends up set.
- R7: An `ack_i` sampled while `irq_o` is high clears the granted latch and the global enable, and `irq_o` is low after that edge. An `ack_i` sampled while `irq_o` is low has no effect.
- R8: From the edge where `irq_o` rises until the acknowledge edge, `irq_o` and `vec_o` do not change. This holds even if a better-ranked request, a mask change or a clear strobe arrives.
- R9: `gie_set_i` turns the global enable on and `gie_clr_i` turns it off. When a clear (strobe or acknowledge) and a set occur in the same cycle, the clear wins.
- R10: `vec_o` reads 0 whenever `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_req_i | input | 2 | External sources, bit 0 high rank, bit 1 low rank (asynchronous) |
| tmr_evt_i | input | 4 | Internal events: fast timer, timer A, timer B, time base |
| mask_i | input | 4 | Mask word gating individual sources |
| gie_set_i | input | 1 | Global enable set strobe |
| gie_clr_i | input | 1 | Global enable clear strobe |
| clr_i | input | 6 | Software clear strobes, bit k clears rank k |
| ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 12 | Entry address of the granted source |

## Verification
The outputs fall due on different schedules. A latched internal event shows on `irq_o` two edges after it is sampled. An external pin needs four edges because of its synchronizer. An acknowledge takes `irq_o` low on the very edge that samples it, and mask or enable changes act on the next capture edge.

The bench models these latencies cycle by cycle. It drives inputs on the falling edge, advances its model on the rising edge, and compares `irq_o` and `vec_o` on every following falling edge. Because of this, a one-cycle slip in any path shows up as a miscompare.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 6;
  localparam int RANK_W  = $clog2(NSRC);
  localparam int NMASK   = 4;

  typedef enum logic [RANK_W-1:0] {
    RK_EXT_HI = 3'd0,
    RK_FAST   = 3'd1,
    RK_TMA    = 3'd2,
    RK_TMB    = 3'd3,
    RK_TBASE  = 3'd4,
    RK_EXT_LO = 3'd5
  } rank_e;

  typedef logic [NSRC-1:0] src_vec_t;

  // Per-rank gate: global enable plus the mask bit the rank depends on.
  function automatic src_vec_t gate_vec(input logic gie, input logic [NMASK-1:0] msk);
    src_vec_t g;
    g[RK_EXT_HI] = gie;
    g[RK_FAST]   = gie & msk[3];
    g[RK_TMA]    = gie & msk[2];
    g[RK_TMB]    = gie & msk[1];
    g[RK_TBASE]  = gie;
    g[RK_EXT_LO] = gie & msk[0];
    return g;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter bit SYNC   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_s;
  logic [W-1:0] prev_q;

  generate
    if (SYNC) begin : g_sync
      logic [W-1:0] chain_q [STAGES];
      logic [W-1:0] chain_d [STAGES];
      always_comb begin
        chain_d[0] = lvl_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
          for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
      end
      assign lvl_s = chain_q[STAGES-1];
    end else begin : g_direct
      assign lvl_s = lvl_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_s;
  end

  assign rise_o = lvl_s & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  // A set arriving in the same cycle as a clear wins, so no event is lost.
  always_comb begin
    for (int k = 0; k < N; k++) begin
      pend_d[k] = set_i[k] | (pend_q[k] & ~clr_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N   = 6,
  parameter int IDX = 3
) (
  input  logic [N-1:0]   elig_i,
  output logic           any_o,
  output logic [IDX-1:0] idx_o
);
  // Scan from the lowest rank upward; the last write wins, so rank 0 dominates.
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig_i[k]) idx_o = IDX'(k);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_BASE = 2,
  parameter int VEC_STEP = 2,
  parameter int N_EXT    = 2,
  parameter int N_INT    = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_INT-1:0]  tmr_evt_i,
  input  logic [NMASK-1:0]  mask_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o
);
  // Reset synchronizer: asserts at once, releases on a clock edge.
  logic rst_meta_q, rst_n_sync;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  logic [N_EXT-1:0] ext_rise;
  logic [N_INT-1:0] int_rise;

  irq_edge_det #(.W(N_EXT), .STAGES(SYNC_LEN), .SYNC(1'b1)) u_ext_edge (
    .clk_i (clk_i), .rst_ni(rst_n_sync), .lvl_i(ext_req_i), .rise_o(ext_rise)
  );
  irq_edge_det #(.W(N_INT), .STAGES(SYNC_LEN), .SYNC(1'b0)) u_int_edge (
    .clk_i (clk_i), .rst_ni(rst_n_sync), .lvl_i(tmr_evt_i), .rise_o(int_rise)
  );

  // Arrange the rising edges in rank order.
  src_vec_t rise_rk;
  assign rise_rk = {ext_rise[1], int_rise, ext_rise[0]};

  logic              gie_q, gie_d;
  logic              irq_q, irq_d;
  logic [RANK_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic              ack_take;
  src_vec_t          pend_q, elig, clr_vec;
  logic              any_elig;
  logic [RANK_W-1:0] pick_idx;

  assign ack_take = ack_i & irq_q;

  always_comb begin
    clr_vec = clr_i;
    if (ack_take) clr_vec[idx_q] = 1'b1;
  end

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk_i (clk_i), .rst_ni(rst_n_sync), .set_i(rise_rk), .clr_i(clr_vec), .pend_o(pend_q)
  );

  assign elig = pend_q & gate_vec(gie_q, mask_i);

  irq_prio_pick #(.N(NSRC), .IDX(RANK_W)) u_pick (
    .elig_i(elig), .any_o(any_elig), .idx_o(pick_idx)
  );

  // Next-state logic
  always_comb begin
    gie_d  = gie_q;
    if (gie_set_i) gie_d = 1'b1;
    if (gie_clr_i || ack_take) gie_d = 1'b0;

    irq_d  = irq_q ? ~ack_take : any_elig;
    idx_en = ~irq_q & any_elig;
    idx_d  = pick_idx;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      gie_q <= 1'b0;
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      gie_q <= gie_d;
      irq_q <= irq_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = irq_q ? (ADDR_W'(VEC_BASE) + ADDR_W'(idx_q) * ADDR_W'(VEC_STEP)) : '0;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        irq_o,
  input logic [11:0] vec_o,
  input logic        ack_i,
  input logic        gie_q,
  input logic [5:0]  pend_q
);
  logic [5:0] pend_d1;
  logic [2:0] vrank;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pend_d1 <= '0;
    else        pend_d1 <= pend_q;
  end
  assign vrank = vec_o[3:1] - 3'd1;

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !irq_o |-> vec_o == 12'd0); // R10
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o >= 12'd2 && vec_o <= 12'd12)); // R2
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(vec_o)); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o && ack_i |=> !irq_o && !gie_q); // R7
  AST_RAISE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gie_q)); // R3
  AST_GRANT_WAS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> pend_d1[vrank]); // R4
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n_sync),
  .irq_o (irq_o),
  .vec_o (vec_o),
  .ack_i (ack_i),
  .gie_q (gie_q),
  .pend_q(pend_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  ext_req_i;
  logic [3:0]  tmr_evt_i;
  logic [3:0]  mask_i;
  logic        gie_set_i, gie_clr_i, ack_i;
  logic [5:0]  clr_i;
  logic        irq_o;
  logic [11:0] vec_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_prio_ctrl dut_i (
    .clk_i, .rst_ni, .ext_req_i, .tmr_evt_i, .mask_i,
    .gie_set_i, .gie_clr_i, .clr_i, .ack_i, .irq_o, .vec_o
  );

  // ---------------- reference model built from the requirements ----------
  logic [1:0] m_s1, m_s2, m_epv;
  logic [3:0] m_tpv;
  logic [5:0] m_pend;
  logic       m_gie, m_irq;
  int         m_idx;

  function automatic logic [5:0] exp_gate(input logic g, input logic [3:0] m);
    return {g & m[0], g, g & m[1], g & m[2], g & m[3], g};   // R3
  endfunction

  function automatic int exp_pick(input logic [5:0] e);      // R2
    for (int k = 0; k < 6; k++) if (e[k]) return k;
    return 0;
  endfunction

  function automatic logic [11:0] exp_vec(input logic irq, input int idx);
    return irq ? 12'(2 + 2 * idx) : 12'd0;                   // R2 R10
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_epv = '0; m_tpv = '0;
      m_pend = '0; m_gie = 1'b0; m_irq = 1'b0; m_idx = 0;
    end else begin
      logic [5:0] rise, elig, clrv;
      logic       take, n_gie, n_irq;
      int         n_idx;
      rise  = {m_s2[1] & ~m_epv[1], tmr_evt_i & ~m_tpv, m_s2[0] & ~m_epv[0]};
      elig  = m_pend & exp_gate(m_gie, mask_i);
      take  = ack_i & m_irq;
      clrv  = clr_i;
      if (take) clrv[m_idx] = 1'b1;
      n_gie = m_gie;
      if (gie_set_i) n_gie = 1'b1;
      if (gie_clr_i || take) n_gie = 1'b0;
      n_idx = m_idx;
      if (m_irq) n_irq = ~take;
      else begin
        n_irq = |elig;
        if (|elig) n_idx = exp_pick(elig);
      end
      m_pend = (m_pend & ~clrv) | rise;
      m_gie = n_gie; m_irq = n_irq; m_idx = n_idx;
      m_epv = m_s2; m_s2 = m_s1; m_s1 = ext_req_i; m_tpv = tmr_evt_i;
    end
  end

  // ---------------- checking --------------------------------------------
  task automatic tick();
    logic [11:0] ev;
    @(negedge clk_i);
    ev = exp_vec(m_irq, m_idx);
    n_chk++;
    if (irq_o !== m_irq || vec_o !== ev) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b vec_o=0x%03h expected irq_o=%0b vec_o=0x%03h at %0t",
               cur_req, irq_o, vec_o, m_irq, ev, $time);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic strobes_off();
    gie_set_i = 1'b0; gie_clr_i = 1'b0; clr_i = '0; ack_i = 1'b0; tmr_evt_i = '0;
  endtask

  task automatic pulse_tmr(input logic [3:0] v);
    tmr_evt_i = v; tick(); tmr_evt_i = '0;
  endtask

  task automatic set_gie();
    gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; ext_req_i = '0; mask_i = '0; strobes_off();
    cur_req = "R1 reset"; run(4);
    rst_ni = 1'b1; run(4);

    // R4 external path latency and ext-high vector
    cur_req = "R4 ext sync latency";
    set_gie();
    ext_req_i[0] = 1'b1; run(6);
    cur_req = "R7 ack clears"; do_ack(); run(3);
    cur_req = "R4 level held no refire"; set_gie(); run(6);
    ext_req_i[0] = 1'b0; run(3);

    // R3 gating: only time base passes with masks off
    cur_req = "R3 gating"; mask_i = 4'h0;
    pulse_tmr(4'b0111); run(3);
    pulse_tmr(4'b1000); run(3);
    do_ack(); run(2);
    set_gie(); run(3);
    // R5 masked requests serviced once unmasked, best rank first
    cur_req = "R5 unmask"; mask_i = 4'b0100; run(3); do_ack();
    set_gie(); mask_i = 4'hF; run(3); do_ack();
    set_gie(); run(3); do_ack(); run(2);

    // R8 hold while better rank arrives
    cur_req = "R8 hold"; set_gie(); ext_req_i[1] = 1'b1; run(6);
    pulse_tmr(4'b0001); mask_i = 4'h0; clr_i = 6'b100000; tick(); clr_i = '0;
    run(4); mask_i = 4'hF; do_ack(); ext_req_i[1] = 1'b0;
    set_gie(); run(3); do_ack(); run(2);

    // R6 clear strobe, and clear colliding with a rising edge
    cur_req = "R6 clear"; mask_i = 4'h0; pulse_tmr(4'b0010); run(1);
    clr_i = 6'b000100; tick(); clr_i = '0;
    tmr_evt_i = 4'b0100; clr_i = 6'b001000; tick(); tmr_evt_i = '0; clr_i = '0;
    set_gie(); mask_i = 4'hF; run(3); do_ack(); run(2);

    // R7 ack ignored while idle; R9 clear wins over set
    cur_req = "R7 idle ack"; do_ack(); do_ack(); run(2);
    cur_req = "R9 gie priority"; gie_set_i = 1'b1; gie_clr_i = 1'b1; tick();
    strobes_off(); pulse_tmr(4'b1000); run(4);
    set_gie(); run(3); do_ack(); run(2);

    // Random phase covering R2 R8 R7 R5 R6 R9
    cur_req = "R2 random";
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 15) == 0) ext_req_i[$urandom_range(0, 1)] ^= 1'b1;
      tmr_evt_i = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 40) == 0) mask_i = 4'($urandom);
      gie_set_i = ($urandom_range(0, 5) == 0);
      gie_clr_i = ($urandom_range(0, 25) == 0);
      clr_i = ($urandom_range(0, 20) == 0) ? 6'($urandom) : 6'h0;
      ack_i = ($urandom_range(0, 3) == 0);
      tick();
    end
    strobes_off(); run(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule